// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the host-facing programming port of a four-channel DMA controller. A host issues byte-wide reads and writes into a 16-entry I/O window. The block decodes each access into per-channel address and count registers or into the shared control registers: command, status, request, mask and mode. Each channel's 16-bit address and count registers are reached through one 8-bit offset. A single internal byte pointer decides whether an access goes to the low byte or the high byte. Host software first resets that pointer, then moves each 16-bit value low byte first.

The block drives the stored command, masks, requests, per-channel mode and base address/count values to the transfer engines, which sit outside this block. The engines return terminal-count pulses, which the block records as status flags. An engine can also reload a channel's current address and count, for example after an auto-initialise. The host reads the current values back through the same byte-pointer scheme.

Top module: `dma_regif`

## Requirements
- R1: After reset the byte pointer selects the low byte, all four mask bits are 1, and the command, request, terminal-count flags, modes and all base and current address and count values are 0.
- R2: Channel c has its address register at offset 2c and its count register at offset 2c+1. Every read or write at an offset below 0x8 flips the byte pointer, and the access goes to the low byte when the pointer is clear and to the high byte when it is set. A write stores the byte in both the base copy and the current copy.
- R3: A write of any value to offset 0xC clears the byte pointer, so the next 16-bit access goes to the low byte.
- R4: A read at offset 2c or 2c+1 returns the selected byte of channel c's current address or current count, on rdata_o during the read cycle.
- R5: A write to offset 0xA sets the mask of channel wdata[1:0] to wdata[2]. Masks change only on writes to 0xA, 0xD, 0xE or 0xF.
- R6: A write to 0xF loads mask bit c from wdata[c] for c = 0..3. A write of any value to 0xE clears all four masks.
- R7: A write to 0xB stores wdata[7:2] as the mode of channel wdata[1:0], on mode_o bits [6c+5:6c]. For that channel, cascade_o is 1 when wdata[7:6] = 11 and autoinit_o is 1 when wdata[4] = 1.
- R8: A write to 0x8 stores the byte on cmd_o. Reads at offsets 0x9 to 0xF return 0.
- R9: A write to 0x9 sets the request bit of channel wdata[1:0] to wdata[2], on req_o.
- R10: A pulse on tc_i[c] sets the terminal-count flag of channel c. A read at 0x8 returns the pending requests in bits 7:4 and the flags in bits 3:0, and then clears the flags. A pulse that arrives in the same cycle as that read remains set.
- R11: A write of any value to 0xD clears the command, requests, flags and byte pointer and sets all four masks. It leaves the modes and the address and count values unchanged.
- R12: When eng_ld_i[c] is high, channel c's current address and count load from eng_addr_i and eng_cnt_i, and the base values stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register offset of the access |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Read data for the current offset |
| tc_i | input | 4 | Terminal-count pulses from the engines |
| eng_ld_i | input | 4 | Per-channel reload of the current address and count |
| eng_addr_i | input | 64 | Reload addresses, 16 bits per channel |
| eng_cnt_i | input | 64 | Reload counts, 16 bits per channel |
| cmd_o | output | 8 | Command register |
| mask_o | output | 4 | Per-channel mask |
| req_o | output | 4 | Software request bits |
| mode_o | output | 24 | Per-channel mode, 6 bits per channel |
| cascade_o | output | 4 | Channel is in cascade mode |
| autoinit_o | output | 4 | Channel has auto-initialise enabled |
| base_addr_o | output | 64 | Base addresses, 16 bits per channel |
| base_cnt_o | output | 64 | Base counts, 16 bits per channel |

## Verification
The assertions assume that wr_i and rd_i are never high together, that every access lasts exactly one cycle, and that all inputs are known while out of reset. The stimulus raises at most one strobe in each cycle and drives every input at the falling edge. Random stimulus mixes all sixteen offsets with terminal-count pulses and engine reloads. In any one cycle it issues an engine reload only to channels the host is not writing, so the order between a host write and a reload is never relied on.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;
  localparam int unsigned CH_W   = 2;
  localparam int unsigned NCH    = 1 << CH_W;
  localparam int unsigned DW     = 8;
  localparam int unsigned RW     = 2 * DW;
  localparam int unsigned MW     = DW - CH_W;
  localparam int unsigned AW     = 4;

  typedef enum logic [AW-1:0] {
    OFF_CMD     = 4'h8,
    OFF_REQ     = 4'h9,
    OFF_SMASK   = 4'hA,
    OFF_MODE    = 4'hB,
    OFF_CLRPTR  = 4'hC,
    OFF_MCLR    = 4'hD,
    OFF_CLRMASK = 4'hE,
    OFF_ALLMASK = 4'hF
  } ctrl_off_e;
endpackage

// File: rtl/dma_regif_ptr.sv
module dma_regif_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= 1'b0;
    else if (clr_i)  ptr_o <= 1'b0;
    else if (step_i) ptr_o <= ~ptr_o;
  end
endmodule

// File: rtl/dma_regif_chan.sv
module dma_regif_chan #(
  parameter int unsigned DW = dma_regif_pkg::DW,
  localparam int unsigned RW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_addr_i,
  input  logic          wr_cnt_i,
  input  logic          hi_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ld_i,
  input  logic [RW-1:0] ld_addr_i,
  input  logic [RW-1:0] ld_cnt_i,
  output logic [RW-1:0] base_addr_o,
  output logic [RW-1:0] base_cnt_o,
  output logic [RW-1:0] cur_addr_o,
  output logic [RW-1:0] cur_cnt_o
);
  logic host_wr;
  logic [RW-1:0] merged_addr, merged_cnt;

  assign host_wr = wr_addr_i | wr_cnt_i;

  always_comb begin
    merged_addr = base_addr_o;
    merged_cnt  = base_cnt_o;
    if (hi_i) begin
      merged_addr[RW-1:DW] = wdata_i;
      merged_cnt[RW-1:DW]  = wdata_i;
    end else begin
      merged_addr[DW-1:0] = wdata_i;
      merged_cnt[DW-1:0]  = wdata_i;
    end
  end

  // host write wins over an engine reload in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_o <= '0;
      base_cnt_o  <= '0;
      cur_addr_o  <= '0;
      cur_cnt_o   <= '0;
    end else if (host_wr) begin
      if (wr_addr_i) begin
        base_addr_o <= merged_addr;
        if (hi_i) cur_addr_o[RW-1:DW] <= wdata_i;
        else      cur_addr_o[DW-1:0]  <= wdata_i;
      end
      if (wr_cnt_i) begin
        base_cnt_o <= merged_cnt;
        if (hi_i) cur_cnt_o[RW-1:DW] <= wdata_i;
        else      cur_cnt_o[DW-1:0]  <= wdata_i;
      end
    end else if (ld_i) begin
      cur_addr_o <= ld_addr_i;
      cur_cnt_o  <= ld_cnt_i;
    end
  end
endmodule

// File: rtl/dma_regif_ctrl.sv
module dma_regif_ctrl #(
  parameter int unsigned NCH  = dma_regif_pkg::NCH,
  parameter int unsigned CH_W = dma_regif_pkg::CH_W,
  parameter int unsigned DW   = dma_regif_pkg::DW,
  localparam int unsigned MW  = DW - CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cmd_i,
  input  logic              wr_req_i,
  input  logic              wr_smask_i,
  input  logic              wr_mode_i,
  input  logic              wr_mclr_i,
  input  logic              wr_clrmask_i,
  input  logic              wr_allmask_i,
  input  logic              rd_stat_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NCH-1:0]    tc_i,
  output logic [DW-1:0]     cmd_o,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH-1:0]    req_o,
  output logic [NCH*MW-1:0] mode_o,
  output logic [NCH-1:0]    tc_o
);
  logic [CH_W-1:0] sel;
  logic            bitval;

  assign sel    = wdata_i[CH_W-1:0];
  assign bitval = wdata_i[CH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmd_o <= '0;
    else if (wr_mclr_i) cmd_o <= '0;
    else if (wr_cmd_i)  cmd_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            mask_o <= '1;
    else if (wr_mclr_i)     mask_o <= '1;
    else if (wr_clrmask_i)  mask_o <= '0;
    else if (wr_allmask_i)  mask_o <= wdata_i[NCH-1:0];
    else if (wr_smask_i)    mask_o[sel] <= bitval;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         req_o <= '0;
    else if (wr_mclr_i)  req_o <= '0;
    else if (wr_req_i)   req_o[sel] <= bitval;
  end

  // a pulse arriving with the clearing read is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tc_o <= '0;
    else if (wr_mclr_i)  tc_o <= '0;
    else if (rd_stat_i)  tc_o <= tc_i;
    else                 tc_o <= tc_o | tc_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mode_o[c*MW +: MW] <= '0;
      else if (wr_mode_i && (sel == CH_W'(c)))
        mode_o[c*MW +: MW] <= wdata_i[DW-1:CH_W];
    end
  end
endmodule

// File: rtl/dma_regif.sv
module dma_regif
  import dma_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NCH-1:0]    tc_i,
  input  logic [NCH-1:0]    eng_ld_i,
  input  logic [NCH*RW-1:0] eng_addr_i,
  input  logic [NCH*RW-1:0] eng_cnt_i,
  output logic [DW-1:0]     cmd_o,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH-1:0]    req_o,
  output logic [NCH*MW-1:0] mode_o,
  output logic [NCH-1:0]    cascade_o,
  output logic [NCH-1:0]    autoinit_o,
  output logic [NCH*RW-1:0] base_addr_o,
  output logic [NCH*RW-1:0] base_cnt_o
);
  logic            is_chan;
  logic [CH_W-1:0] ch_sel;
  logic            ptr_q;
  logic [NCH-1:0]  tc_q;
  logic [RW-1:0]   cur_addr [NCH];
  logic [RW-1:0]   cur_cnt  [NCH];
  logic [RW-1:0]   rd_word;

  assign is_chan = ~addr_i[AW-1];
  assign ch_sel  = addr_i[CH_W:1];

  dma_regif_ptr u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_i && ((addr_i == OFF_CLRPTR) || (addr_i == OFF_MCLR))),
    .step_i ((wr_i || rd_i) && is_chan),
    .ptr_o  (ptr_q)
  );

  dma_regif_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_cmd_i     (wr_i && (addr_i == OFF_CMD)),
    .wr_req_i     (wr_i && (addr_i == OFF_REQ)),
    .wr_smask_i   (wr_i && (addr_i == OFF_SMASK)),
    .wr_mode_i    (wr_i && (addr_i == OFF_MODE)),
    .wr_mclr_i    (wr_i && (addr_i == OFF_MCLR)),
    .wr_clrmask_i (wr_i && (addr_i == OFF_CLRMASK)),
    .wr_allmask_i (wr_i && (addr_i == OFF_ALLMASK)),
    .rd_stat_i    (rd_i && (addr_i == OFF_CMD)),
    .wdata_i      (wdata_i),
    .tc_i         (tc_i),
    .cmd_o        (cmd_o),
    .mask_o       (mask_o),
    .req_o        (req_o),
    .mode_o       (mode_o),
    .tc_o         (tc_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic hit;
    assign hit = wr_i && is_chan && (ch_sel == CH_W'(c));

    dma_regif_chan u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_addr_i   (hit && !addr_i[0]),
      .wr_cnt_i    (hit && addr_i[0]),
      .hi_i        (ptr_q),
      .wdata_i     (wdata_i),
      .ld_i        (eng_ld_i[c]),
      .ld_addr_i   (eng_addr_i[c*RW +: RW]),
      .ld_cnt_i    (eng_cnt_i[c*RW +: RW]),
      .base_addr_o (base_addr_o[c*RW +: RW]),
      .base_cnt_o  (base_cnt_o[c*RW +: RW]),
      .cur_addr_o  (cur_addr[c]),
      .cur_cnt_o   (cur_cnt[c])
    );

    assign cascade_o[c]  = &mode_o[c*MW+MW-1 -: 2];
    assign autoinit_o[c] = mode_o[c*MW+2];
  end

  assign rd_word = addr_i[0] ? cur_cnt[ch_sel] : cur_addr[ch_sel];

  always_comb begin
    if (is_chan)                 rdata_o = ptr_q ? rd_word[RW-1:DW] : rd_word[DW-1:0];
    else if (addr_i == OFF_CMD)  rdata_o = {req_o, tc_q};
    else                         rdata_o = '0;
  end
endmodule

// File: rtl/dma_regif_chk.sv
module dma_regif_chk
  import dma_regif_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic [AW-1:0]  addr_i,
  input logic [DW-1:0]  wdata_i,
  input logic           wr_i,
  input logic           rd_i,
  input logic [NCH-1:0] tc_i,
  input logic [DW-1:0]  cmd_o,
  input logic [NCH-1:0] mask_o,
  input logic [NCH-1:0] req_o,
  input logic           ptr_q,
  input logic [NCH-1:0] tc_q
);
  logic mask_wr;
  assign mask_wr = wr_i && (addr_i == OFF_SMASK || addr_i == OFF_MCLR ||
                            addr_i == OFF_CLRMASK || addr_i == OFF_ALLMASK);

  AST_PTR_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || rd_i) && !addr_i[AW-1] |=> ptr_q != $past(ptr_q)); // R2
  AST_PTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFF_CLRPTR |=> !ptr_q); // R3
  AST_SINGLE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFF_SMASK |=> mask_o[$past(wdata_i[1:0])] == $past(wdata_i[2])); // R5
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr |=> $stable(mask_o)); // R5
  AST_ALL_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFF_ALLMASK |=> mask_o == $past(wdata_i[NCH-1:0])); // R6
  AST_TC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == OFF_CMD |=> tc_q == $past(tc_i)); // R10
  AST_MCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFF_MCLR |=> (&mask_o) && cmd_o == '0 && req_o == '0 && !ptr_q && tc_q == '0); // R11
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && rd_i)); // R2
endmodule

bind dma_regif dma_regif_chk u_chk (.*);

// File: tb/dma_regif_tb.sv
`timescale 1ns/1ps
module dma_regif_tb;
  localparam int NCH = 4, RW = 16, MW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic [3:0] tc = '0, eng_ld = '0;
  logic [NCH*RW-1:0] eng_addr = '0, eng_cnt = '0;
  logic [7:0] cmd;
  logic [3:0] mask, req, cascade, autoinit;
  logic [NCH*MW-1:0] mode;
  logic [NCH*RW-1:0] base_addr, base_cnt;

  always #4 clk = ~clk;

  dma_regif u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .tc_i(tc), .eng_ld_i(eng_ld), .eng_addr_i(eng_addr), .eng_cnt_i(eng_cnt),
    .cmd_o(cmd), .mask_o(mask), .req_o(req), .mode_o(mode), .cascade_o(cascade),
    .autoinit_o(autoinit), .base_addr_o(base_addr), .base_cnt_o(base_cnt)
  );

  logic [15:0] m_ba [NCH], m_bc [NCH], m_ca [NCH], m_cc [NCH];
  logic [5:0]  m_mode [NCH];
  logic [3:0]  m_mask, m_req, m_tc;
  logic [7:0]  m_cmd;
  logic        m_ptr;
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [3:0] a);
    logic [15:0] w;
    if (!a[3]) begin
      w = a[0] ? m_cc[a[2:1]] : m_ca[a[2:1]];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (a == 4'h8) return {m_req, m_tc};
    return 8'h00;
  endfunction

  task automatic chk_state(string tag);
    chk({tag, " R5 mask"}, mask, m_mask);
    chk({tag, " R9 req"}, req, m_req);
    chk({tag, " R8 cmd"}, cmd, m_cmd);
    for (int c = 0; c < NCH; c++) begin
      chk({tag, " R2 base_addr"}, base_addr[c*RW +: RW], m_ba[c]);
      chk({tag, " R2 base_cnt"}, base_cnt[c*RW +: RW], m_bc[c]);
      chk({tag, " R7 mode"}, mode[c*MW +: MW], m_mode[c]);
      chk({tag, " R7 cascade"}, cascade[c], &m_mode[c][5:4]);
      chk({tag, " R7 autoinit"}, autoinit[c], m_mode[c][2]);
    end
  endtask

  task automatic model_step(logic w, logic r, logic [3:0] a, logic [7:0] d,
                            logic [3:0] t, logic [3:0] ld);
    if (w && a == 4'hD) m_tc = '0;
    else if (r && a == 4'h8) m_tc = t;
    else m_tc = m_tc | t;
    for (int c = 0; c < NCH; c++)
      if (ld[c] && !(w && !a[3] && a[2:1] == c[1:0])) begin
        m_ca[c] = eng_addr[c*RW +: RW];
        m_cc[c] = eng_cnt[c*RW +: RW];
      end
    if (!a[3] && (w || r)) begin
      if (w) begin
        if (a[0]) begin
          if (m_ptr) begin m_bc[a[2:1]][15:8] = d; m_cc[a[2:1]][15:8] = d; end
          else       begin m_bc[a[2:1]][7:0]  = d; m_cc[a[2:1]][7:0]  = d; end
        end else begin
          if (m_ptr) begin m_ba[a[2:1]][15:8] = d; m_ca[a[2:1]][15:8] = d; end
          else       begin m_ba[a[2:1]][7:0]  = d; m_ca[a[2:1]][7:0]  = d; end
        end
      end
      m_ptr = ~m_ptr;
    end else if (w) begin
      case (a)
        4'h8: m_cmd = d;
        4'h9: m_req[d[1:0]] = d[2];
        4'hA: m_mask[d[1:0]] = d[2];
        4'hB: m_mode[d[1:0]] = d[7:2];
        4'hC: m_ptr = 1'b0;
        4'hD: begin m_cmd = '0; m_req = '0; m_ptr = 1'b0; m_mask = 4'hF; end
        4'hE: m_mask = 4'h0;
        default: m_mask = d[3:0];
      endcase
    end
  endtask

  task automatic op(logic w, logic r, logic [3:0] a, logic [7:0] d,
                    logic [3:0] t, logic [3:0] ld, string tag);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; tc = t; eng_ld = ld;
    for (int c = 0; c < NCH; c++) begin
      eng_addr[c*RW +: RW] = 16'($urandom);
      eng_cnt[c*RW +: RW]  = 16'($urandom);
    end
    #1;
    if (r) chk({tag, " R4 rdata"}, rdata, exp_read(a));
    @(posedge clk);
    model_step(w, r, a, d, t, ld);
    #1;
    chk_state(tag);
  endtask

  task automatic wrb(logic [3:0] a, logic [7:0] d, string tag);
    op(1, 0, a, d, 4'h0, 4'h0, tag);
  endtask
  task automatic rdb(logic [3:0] a, string tag);
    op(0, 1, a, 8'h00, 4'h0, 4'h0, tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < NCH; c++) begin
      m_ba[c] = '0; m_bc[c] = '0; m_ca[c] = '0; m_cc[c] = '0; m_mode[c] = '0;
    end
    m_mask = 4'hF; m_req = '0; m_tc = '0; m_cmd = '0; m_ptr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_state("R1 reset");
    chk("R1 status", {req, u_dut.rdata_o & 8'h00}, 12'h0);
    rdb(4'h8, "R1 status read");
    rdb(4'h0, "R1 ptr low");
    rdb(4'h0, "R1 ptr high");

    // 16-bit writes and readback, channel 2
    wrb(4'hC, 8'h5A, "R3");
    wrb(4'h4, 8'h34, "R2 lo");
    wrb(4'h4, 8'h12, "R2 hi");
    chk("R2 ch2 addr", base_addr[2*RW +: RW], 16'h1234);
    wrb(4'h5, 8'hCD, "R2 cnt lo");
    wrb(4'h5, 8'hAB, "R2 cnt hi");
    rdb(4'h5, "R4 cnt lo");
    rdb(4'h5, "R4 cnt hi");
    // pointer clear mid-pair: second write lands in low byte again
    wrb(4'h6, 8'h11, "R3 lo");
    wrb(4'hC, 8'h00, "R3 clr");
    wrb(4'h6, 8'h22, "R3 relo");
    rdb(4'h6, "R3 ptr now high");
    wrb(4'hC, 8'h00, "R3 clr2");
    // modes
    wrb(4'hB, 8'hC1, "R7 cascade");
    wrb(4'hB, 8'h12, "R7 autoinit");
    // masks
    wrb(4'hE, 8'h00, "R6 clear all");
    wrb(4'hA, 8'h07, "R5 set ch3");
    wrb(4'hA, 8'h03, "R5 clr ch3");
    wrb(4'hF, 8'hFA, "R6 write all");
    // requests and status
    wrb(4'h9, 8'h05, "R9 set ch1");
    op(0, 0, 4'h0, 8'h00, 4'h9, 4'h0, "R10 tc pulse");
    op(0, 1, 4'h8, 8'h00, 4'h2, 4'h0, "R10 read with tc");
    rdb(4'h8, "R10 kept tc");
    rdb(4'h8, "R10 cleared");
    wrb(4'h8, 8'hA5, "R8 cmd");
    rdb(4'hD, "R8 temp read");
    // engine reload
    op(0, 0, 4'h8, 8'h00, 4'h0, 4'h4, "R12 reload");
    wrb(4'hC, 8'h00, "R12 clr");
    rdb(4'h4, "R12 cur lo");
    rdb(4'h4, "R12 cur hi");
    // master clear
    wrb(4'h0, 8'h77, "R11 ptr odd");
    op(0, 0, 4'h0, 8'h00, 4'hF, 4'h0, "R11 tc");
    wrb(4'hD, 8'h3C, "R11 mclr");
    rdb(4'h8, "R11 status");
    rdb(4'h5, "R11 ptr low");
    wrb(4'hC, 8'h00, "R11 clr");

    for (int i = 0; i < 2000; i++) begin
      logic w, r;
      logic [3:0] a, t, ld;
      logic [7:0] d;
      a = 4'($urandom);
      d = 8'($urandom);
      w = ($urandom % 2) == 0;
      r = !w && (($urandom % 4) != 0);
      t = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      ld = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
      if (w && !a[3]) ld[a[2:1]] = 1'b0;
      if (w && a == 4'hD && ($urandom % 4) != 0) a = 4'hA;
      op(w, r, a, d, t, ld, "R12 random");
    end

    @(negedge clk);
    wr = 0; rd = 0; tc = '0; eng_ld = '0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule